// File: doc/BRIEF.md
# Output Word Rate Conversion Sequencer

This block paces conversions for a sigma-delta converter from one master clock. A free-running prescaler produces the modulator sample strobe and a square-wave chopper clock for the input amplifier. A conversion controller counts modulator strobes to mark when each output word is due. A word is released only once the decimation filter has settled for the selected rate.

Rates come from one select bit and a 4-bit step code. The select bit picks one of two rate families. Within a family, each step up in the code halves the word rate. A conversion either produces one settled word and stops, or streams every word after the first settled one. A small path selector also enables either the unity-gain buffer or the amplifier, depending on the gain code.

Top module: `owr_conv_seq`

## Requirements
- R1: While reset is held, the outputs are: `word_stb_o`, `drdy_o`, `busy_o` and `sinc3_en_o` at 0, `buf_en_o` at 1, `amp_en_o` at 0, `mod_stb_o` at 0 and `chop_o` at 0.
- R2: `mod_stb_o` is a one-cycle pulse that repeats every MOD_DIV master-clock cycles. The first pulse after reset falls in cycle MOD_DIV.
- R3: `chop_o` is a square wave with a period of CHOP_DIV cycles. After reset it is low for the first CHOP_DIV/2 cycles and high for the next CHOP_DIV/2.
- R4: The step code k is clamped to 9, so codes 10 to 15 behave as 9. The decimation ratio is D = B·2^k. B is BASE_HI (default 80) when `frs_i`=0, and BASE_LO (default 96) when `frs_i`=1. Code 0 is the fastest rate.
- R5: In continuous mode, after the first word, a word is released every D modulator strobes. That is D·MOD_DIV master cycles between word pulses.
- R6: After an accepted start, the first word is released on strobe number S counted from the start. S = 5·B for code 0, and S = 5·B + 3·D otherwise. `word_stb_o` is high in the cycle after that strobe.
- R7: In single mode, exactly one word is released, and `busy_o` falls in the same cycle as that word pulse.
- R8: A start pulse seen while a single conversion is running is ignored. Its timing and latched settings are unchanged.
- R9: `drdy_o` rises together with `word_stb_o`. It is cleared by `rd_ack_i` or by an accepted start. A new word on the same edge as `rd_ack_i` keeps `drdy_o` high.
- R10: `sinc3_en_o` is 1 when the step code latched at the last accepted start is nonzero.
- R11: One cycle after `gain_code_i`=0 is sampled, `buf_en_o`=1 and `amp_en_o`=0. Any nonzero code gives the opposite.
- R12: A start is accepted when the block is idle or streaming. It latches `frs_i`, `rate_code_i` and `cont_mode_i`, clears `drdy_o`, and restarts settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frs_i | input | 1 | Rate family select |
| rate_code_i | input | 4 | Word-rate step code |
| cont_mode_i | input | 1 | 1 = continuous, 0 = single |
| start_i | input | 1 | Conversion start pulse |
| rd_ack_i | input | 1 | Word read acknowledge |
| gain_code_i | input | 3 | Gain code, 0 = unity |
| mod_stb_o | output | 1 | Modulator sample strobe |
| chop_o | output | 1 | Amplifier chopper clock |
| word_stb_o | output | 1 | One-cycle word release pulse |
| drdy_o | output | 1 | Data-ready flag |
| busy_o | output | 1 | Conversion in progress |
| sinc3_en_o | output | 1 | Second filter stage in use |
| buf_en_o | output | 1 | Unity-gain buffer path enable |
| amp_en_o | output | 1 | Amplifier path enable |

## Verification
Every output comes from a register. A start sampled at an edge changes `busy_o` and `drdy_o` in the next cycle. A word pulse appears in the cycle after the strobe that completes the count, so at S·MOD_DIV or D·MOD_DIV cycles from its reference point when starts are aligned to a strobe. The bench drives inputs and samples outputs on the falling edge, against a behavioural model that advances on each rising edge. The timed checks align every start to a strobe, so the release times of R5, R6 and R8 are exact cycle counts rather than windows.

// File: rtl/owr_seq_pkg.sv
package owr_seq_pkg;
  localparam int unsigned MAX_STEP = 9;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_STREAM = 2'd2
  } conv_st_e;
endpackage

// File: rtl/owr_clk_div.sv
module owr_clk_div #(
  parameter int unsigned MOD_DIV  = 16,
  parameter int unsigned CHOP_DIV = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mod_stb_o,
  output logic chop_o
);
  localparam int unsigned PW = (MOD_DIV > 2) ? $clog2(MOD_DIV) : 1;
  localparam int unsigned CW = (CHOP_DIV > 2) ? $clog2(CHOP_DIV) : 1;

  logic [PW-1:0] pre_q;
  logic [CW-1:0] chop_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (pre_q == PW'(MOD_DIV - 1)) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chop_cnt_q <= '0;
    end else if (chop_cnt_q == CW'(CHOP_DIV - 1)) begin
      chop_cnt_q <= '0;
    end else begin
      chop_cnt_q <= chop_cnt_q + CW'(1);
    end
  end

  assign mod_stb_o = (pre_q == PW'(MOD_DIV - 1));
  assign chop_o    = (chop_cnt_q >= CW'(CHOP_DIV / 2));
endmodule

// File: rtl/owr_rate_decode.sv
module owr_rate_decode #(
  parameter int unsigned BASE_HI = 80,
  parameter int unsigned BASE_LO = 96,
  parameter int unsigned CNT_W   = 18
) (
  input  logic             frs_i,
  input  logic [3:0]       code_i,
  output logic [CNT_W-1:0] dec_o,
  output logic [CNT_W-1:0] settle_o,
  output logic             sinc3_o
);
  import owr_seq_pkg::*;

  logic [3:0]       step;
  logic [CNT_W-1:0] base;

  always_comb begin
    step     = (code_i > 4'(MAX_STEP)) ? 4'(MAX_STEP) : code_i;
    base     = frs_i ? CNT_W'(BASE_LO) : CNT_W'(BASE_HI);
    dec_o    = base << step;
    sinc3_o  = (step != 4'd0);
    // top rate: sinc5 only; lower rates add three output periods for sinc3
    settle_o = sinc3_o ? (CNT_W'(5) * base + CNT_W'(3) * dec_o) : (CNT_W'(5) * base);
  end
endmodule

// File: rtl/owr_conv_ctrl.sv
module owr_conv_ctrl #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic             rd_ack_i,
  input  logic             mod_stb_i,
  input  logic [CNT_W-1:0] dec_i,
  input  logic [CNT_W-1:0] settle_i,
  input  logic             sinc3_i,
  output logic             word_o,
  output logic             drdy_o,
  output logic             busy_o,
  output logic             sinc3_en_o
);
  import owr_seq_pkg::*;

  conv_st_e         st_q;
  logic [CNT_W-1:0] cnt_q, tgt_q, dec_q;
  logic             cont_q, sinc3_q, word_q, drdy_q;
  logic             start_ok, hit;

  // a running single conversion owns the sequencer until its word
  assign start_ok = start_i && !((st_q == ST_SETTLE) && !cont_q);
  assign hit      = (st_q != ST_IDLE) && mod_stb_i && (cnt_q == tgt_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      tgt_q   <= '0;
      dec_q   <= '0;
      cont_q  <= 1'b0;
      sinc3_q <= 1'b0;
      word_q  <= 1'b0;
      drdy_q  <= 1'b0;
    end else begin
      word_q <= 1'b0;
      if (start_ok) begin
        st_q    <= ST_SETTLE;
        cnt_q   <= '0;
        tgt_q   <= settle_i;
        dec_q   <= dec_i;
        cont_q  <= cont_i;
        sinc3_q <= sinc3_i;
        drdy_q  <= 1'b0;
      end else begin
        if (hit) begin
          word_q <= 1'b1;
          drdy_q <= 1'b1;
          cnt_q  <= '0;
          if (cont_q) begin
            st_q  <= ST_STREAM;
            tgt_q <= dec_q;
          end else begin
            st_q  <= ST_IDLE;
          end
        end else begin
          if ((st_q != ST_IDLE) && mod_stb_i) cnt_q <= cnt_q + CNT_W'(1);
          if (rd_ack_i) drdy_q <= 1'b0;
        end
      end
    end
  end

  assign word_o     = word_q;
  assign drdy_o     = drdy_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign sinc3_en_o = sinc3_q;
endmodule

// File: rtl/owr_conv_seq.sv
module owr_conv_seq #(
  parameter int unsigned MOD_DIV  = 16,
  parameter int unsigned CHOP_DIV = 128,
  parameter int unsigned BASE_HI  = 80,
  parameter int unsigned BASE_LO  = 96
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frs_i,
  input  logic [3:0] rate_code_i,
  input  logic       cont_mode_i,
  input  logic       start_i,
  input  logic       rd_ack_i,
  input  logic [2:0] gain_code_i,
  output logic       mod_stb_o,
  output logic       chop_o,
  output logic       word_stb_o,
  output logic       drdy_o,
  output logic       busy_o,
  output logic       sinc3_en_o,
  output logic       buf_en_o,
  output logic       amp_en_o
);
  import owr_seq_pkg::*;

  localparam int unsigned MAXB  = (BASE_HI > BASE_LO) ? BASE_HI : BASE_LO;
  localparam int unsigned CNT_W = $clog2(5 * MAXB + 3 * (MAXB << MAX_STEP) + 1);

  logic [CNT_W-1:0] dec, settle;
  logic             sinc3, buf_q;

  owr_clk_div #(.MOD_DIV(MOD_DIV), .CHOP_DIV(CHOP_DIV)) u_div (
    .clk_i, .rst_ni, .mod_stb_o, .chop_o
  );

  owr_rate_decode #(.BASE_HI(BASE_HI), .BASE_LO(BASE_LO), .CNT_W(CNT_W)) u_dec (
    .frs_i, .code_i(rate_code_i), .dec_o(dec), .settle_o(settle), .sinc3_o(sinc3)
  );

  owr_conv_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .cont_i(cont_mode_i), .rd_ack_i,
    .mod_stb_i(mod_stb_o), .dec_i(dec), .settle_i(settle), .sinc3_i(sinc3),
    .word_o(word_stb_o), .drdy_o, .busy_o, .sinc3_en_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) buf_q <= 1'b1;
    else         buf_q <= (gain_code_i == 3'd0);
  end

  assign buf_en_o = buf_q;
  assign amp_en_o = !buf_q;
endmodule

// File: rtl/owr_conv_seq_chk.sv
module owr_conv_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [2:0] gain_code_i,
  input logic       mod_stb_o,
  input logic       word_stb_o,
  input logic       drdy_o,
  input logic       busy_o,
  input logic       buf_en_o,
  input logic       amp_en_o
);
  AST_MOD_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_stb_o |=> !mod_stb_o); // R2
  AST_WORD_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_o |-> $past(mod_stb_o)); // R6
  AST_DRDY_WITH_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_o |-> drdy_o); // R9
  AST_SINGLE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> word_stb_o); // R7
  AST_BUF_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_code_i == 3'd0) |=> (buf_en_o && !amp_en_o)); // R11
  AST_AMP_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_code_i != 3'd0) |=> (amp_en_o && !buf_en_o)); // R11
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (!drdy_o && busy_o)); // R12
endmodule

bind owr_conv_seq owr_conv_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .gain_code_i(gain_code_i),
  .mod_stb_o(mod_stb_o), .word_stb_o(word_stb_o), .drdy_o(drdy_o),
  .busy_o(busy_o), .buf_en_o(buf_en_o), .amp_en_o(amp_en_o)
);

// File: tb/tb_owr_conv_seq.sv
`timescale 1ns/1ps
module tb_owr_conv_seq;
  localparam int MD = 4;
  localparam int CD = 16;
  localparam int BH = 5;
  localparam int BL = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic frs_i = 1'b0, cont_mode_i = 1'b0, start_i = 1'b0, rd_ack_i = 1'b0;
  logic [3:0] rate_code_i = 4'd0;
  logic [2:0] gain_code_i = 3'd0;
  logic mod_stb_o, chop_o, word_stb_o, drdy_o, busy_o, sinc3_en_o, buf_en_o, amp_en_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;

  always #5 clk_i = ~clk_i;

  owr_conv_seq #(.MOD_DIV(MD), .CHOP_DIV(CD), .BASE_HI(BH), .BASE_LO(BL)) dut (
    .clk_i, .rst_ni, .frs_i, .rate_code_i, .cont_mode_i, .start_i, .rd_ack_i,
    .gain_code_i, .mod_stb_o, .chop_o, .word_stb_o, .drdy_o, .busy_o,
    .sinc3_en_o, .buf_en_o, .amp_en_o
  );

  // behavioural reference, advanced on every rising edge
  int m_p, m_c, m_state, m_cnt, m_tgt, m_dec;
  bit m_cont, m_word, m_drdy, m_sinc3, m_buf;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_p = 0; m_c = 0; m_state = 0; m_cnt = 0; m_tgt = 0; m_dec = 0;
      m_cont = 0; m_word = 0; m_drdy = 0; m_sinc3 = 0; m_buf = 1;
    end else begin
      bit strobe, hit;
      int step, base;
      strobe = (m_p == MD - 1);
      hit = 0;
      m_p = (m_p + 1) % MD;
      m_c = (m_c + 1) % CD;
      m_buf = (gain_code_i == 0);
      m_word = 0;
      if (start_i && !(m_state == 1 && !m_cont)) begin
        step = (rate_code_i > 9) ? 9 : int'(rate_code_i);
        base = frs_i ? BL : BH;
        m_dec = base << step;
        m_tgt = (step == 0) ? 5 * base : 5 * base + 3 * m_dec;
        m_cnt = 0; m_state = 1; m_cont = cont_mode_i; m_sinc3 = (step != 0); m_drdy = 0;
      end else begin
        if (m_state != 0 && strobe) begin
          m_cnt++;
          if (m_cnt == m_tgt) begin
            hit = 1; m_word = 1; m_drdy = 1; m_cnt = 0;
            if (m_cont) begin m_state = 2; m_tgt = m_dec; end
            else m_state = 0;
          end
        end
        if (!hit && rd_ack_i) m_drdy = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && cmp_on) begin
      chk(mod_stb_o == (m_p == MD - 1), "R2 mod_stb_o", mod_stb_o, (m_p == MD - 1));
      chk(chop_o == (m_c >= CD / 2), "R3 chop_o", chop_o, (m_c >= CD / 2));
      chk(word_stb_o == m_word, "R6 word_stb_o", word_stb_o, m_word);
      chk(drdy_o == m_drdy, "R9 drdy_o", drdy_o, m_drdy);
      chk(busy_o == (m_state != 0), "R7 busy_o", busy_o, (m_state != 0));
      chk(sinc3_en_o == m_sinc3, "R10 sinc3_en_o", sinc3_en_o, m_sinc3);
      chk(buf_en_o == m_buf, "R11 buf_en_o", buf_en_o, m_buf);
      chk(amp_en_o == !m_buf, "R11 amp_en_o", amp_en_o, !m_buf);
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  // start aligned to a modulator strobe; returns in the cycle after the start edge
  task automatic kick(input bit frs, input logic [3:0] code, input bit cont);
    do @(negedge clk_i); while (!mod_stb_o);
    frs_i = frs; rate_code_i = code; cont_mode_i = cont; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_word(output int cyc);
    cyc = 0;
    do begin @(negedge clk_i); cyc++; end while (!word_stb_o && cyc < 60000);
  endtask

  int t, ta, tb;

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset values
    chk(!word_stb_o && !drdy_o && !busy_o && !sinc3_en_o, "R1 ctrl outputs", {word_stb_o, drdy_o, busy_o, sinc3_en_o}, 0);
    chk(buf_en_o && !amp_en_o, "R1 path select", {buf_en_o, amp_en_o}, 2);
    chk(!mod_stb_o && !chop_o, "R1 clocks", {mod_stb_o, chop_o}, 0);
    rst_ni = 1'b1;
    cmp_on = 1'b1;
    gain_code_i = 3'd5;
    repeat (3) @(negedge clk_i);
    chk(amp_en_o, "R11 amp path", amp_en_o, 1);
    gain_code_i = 3'd0;

    // R6 single at code 0: S = 5*BH
    kick(1'b0, 4'd0, 1'b0);
    wait_word(t);
    chk(t == 5 * BH * MD, "R6 first word code0", t, 5 * BH * MD);
    @(negedge clk_i);
    chk(!busy_o, "R7 single ends", busy_o, 0);
    rd_ack_i = 1'b1; @(negedge clk_i); rd_ack_i = 1'b0;
    chk(!drdy_o, "R9 cleared by ack", drdy_o, 0);

    // R5 continuous, family 1, code 1
    kick(1'b1, 4'd1, 1'b1);
    wait_word(t);
    chk(t == (5 * BL + 3 * (BL << 1)) * MD, "R6 first word code1", t, (5 * BL + 3 * (BL << 1)) * MD);
    wait_word(t);
    chk(t == (BL << 1) * MD, "R5 stream gap", t, (BL << 1) * MD);
    gain_code_i = 3'd3;
    wait_word(t);
    chk(t == (BL << 1) * MD, "R5 stream gap 2", t, (BL << 1) * MD);

    // R12 restart while streaming with new settings
    kick(1'b0, 4'd3, 1'b1);
    chk(!drdy_o && busy_o, "R12 restart clears drdy", drdy_o, 0);
    wait_word(t);
    wait_word(t);
    chk(t == (BH << 3) * MD, "R12 new rate gap", t, (BH << 3) * MD);
    gain_code_i = 3'd0;

    // R8 ignored start during single conversion
    kick(1'b1, 4'd2, 1'b0);
    wait_word(ta);
    chk(ta == (5 * BL + 3 * (BL << 2)) * MD, "R8 reference run", ta, (5 * BL + 3 * (BL << 2)) * MD);
    kick(1'b1, 4'd2, 1'b0);
    repeat (50) @(negedge clk_i);
    rate_code_i = 4'd0; frs_i = 1'b0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(sinc3_en_o, "R8 settings kept", sinc3_en_o, 1);
    wait_word(tb);
    chk(tb + 51 == ta, "R8 timing kept", tb + 51, ta);

    // R4 clamp: code 12 behaves as code 9
    kick(1'b0, 4'd12, 1'b1);
    wait_word(t);
    chk(t == (5 * BH + 3 * (BH << 9)) * MD, "R4 clamped settle", t, (5 * BH + 3 * (BH << 9)) * MD);
    wait_word(t);
    chk(t == (BH << 9) * MD, "R4 clamped gap", t, (BH << 9) * MD);
    kick(1'b0, 4'd0, 1'b0);
    wait_word(t);
    @(negedge clk_i);
    chk(!busy_o && !sinc3_en_o, "R10 code0 no sinc3", sinc3_en_o, 0);

    summary();
    $finish;
  end
endmodule